// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block produces a pulse-width modulated waveform with up to 10 bits of resolution. A prescaler divides the system clock by one of three ratios, and each resulting tick advances a counter. The counter runs from zero up to a programmed period value and then wraps. Software programs the block through four byte-wide registers:

- a control register;
- a low byte for the period;
- a low byte for the duty;
- one shared register that holds the upper bits of both the period and the duty.

The duty value that software writes goes first into a master copy. The comparator uses a separate slave copy. The slave copy is loaded from the master only when the counter reaches the period, so a duty update never cuts a cycle short. A new period value also takes effect only at that wrap. As a result, changing only the period alters the frequency and leaves the absolute active time unchanged.

A polarity bit selects whether the active level is high or low. Two duty settings give a static output: a duty equal to the period, and a duty of zero. An output-enable bit gates the waveform onto the pin. While the timer is stopped, the counter is held at zero and both buffers follow the register contents, so the first cycle after start uses the values just written.

Top module: `pwm10_gen`

## Requirements
- R1: Register map, selected by `wr_addr` and written on a clock with `wr_en` high:
  - address 0 is control: bit0 run, bit1 output enable, bit2 polarity, bits[4:3] clock select;
  - address 1 is the period low byte;
  - address 2 is the duty low byte;
  - address 3 is the shared high register: bits[3:2] are period bits 9:8, and bits[1:0] are duty bits 9:8.
- R2: With period N and duty D, where 0 < D < N, one cycle lasts N+1 ticks and the output is at the active level for D+1 ticks of it.
- R3: Clock select sets the number of system clocks per tick: code 00 gives 1, code 01 gives 2, and codes 10 and 11 both give 8.
- R4: A duty write made while running has no effect on the output until the counter next wraps from the period value to zero.
- R5: A new period value takes effect at the next wrap. After a period-only change, the active time per cycle stays (D+1) ticks.
- R6: When the duty equals the period, the output stays at the active level.
- R7: When the duty is zero and differs from the period, the output stays at the inactive level.
- R8: Polarity 1 makes the active level high. Polarity 0 makes it low, so the waveform is inverted.
- R9: While run is 0, the counter is held at zero and the enabled output sits at the inactive level. Period and duty writes made while stopped apply from the first cycle after start.
- R10: While output enable is 0, `pwm_o` is low.
- R11: `pwm_o` is a register that is cleared by reset. The pin level seen at a clock edge reflects the counter state from before that edge. Reset clears every register, which leaves run and enable off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Register write data |
| pwm_o | output | 1 | Registered PWM pin output |

## Verification
The hardest situation to reach is a duty or period write that lands in the middle of a running cycle at a slow clock ratio, where the old slave value still has to be in force until the wrap. The bench reaches this case with long runs of random register writes spaced a few clocks apart while the timer runs under every clock-select code. A cycle-accurate bench model, built from the requirements, flags any early take-over of the new value. Directed phases then settle into steady state and count active clocks over exactly one period, to check the static cases and the polarity inversion.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
  typedef struct packed {
    logic [1:0] clk_sel;
    logic       pol;
    logic       oe;
    logic       run;
  } ctrl_t;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_PLO  = 2'd1;
  localparam logic [1:0] A_DLO  = 2'd2;
  localparam logic [1:0] A_HI   = 2'd3;
endpackage

// File: rtl/pwm10_regs.sv
module pwm10_regs
  import pwm10_pkg::*;
#(
  parameter int RES   = 10,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output ctrl_t            ctrl,
  output logic [RES-1:0]   per_m,
  output logic [RES-1:0]   duty_m
);
  localparam int HI_W = RES - REG_W;

  logic [REG_W-1:0] plo_q, dlo_q;
  logic [HI_W-1:0]  phi_q, dhi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      plo_q <= '0;
      dlo_q <= '0;
      phi_q <= '0;
      dhi_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: ctrl  <= ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
        A_PLO:  plo_q <= wr_data;
        A_DLO:  dlo_q <= wr_data;
        default: begin
          phi_q <= wr_data[2*HI_W-1:HI_W];
          dhi_q <= wr_data[HI_W-1:0];
        end
      endcase
    end
  end

  assign per_m  = {phi_q, plo_q};
  assign duty_m = {dhi_q, dlo_q};
endmodule

// File: rtl/pwm10_presc.sv
module pwm10_presc #(
  parameter int DIV_A = 1,
  parameter int DIV_B = 2,
  parameter int DIV_C = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int DMAX = (DIV_C > DIV_B) ? ((DIV_C > DIV_A) ? DIV_C : DIV_A)
                                        : ((DIV_B > DIV_A) ? DIV_B : DIV_A);
  localparam int PCW  = $clog2(DMAX + 1);

  logic [PCW-1:0] pc;
  logic [PCW-1:0] lim;

  always_comb begin
    case (sel)
      2'b00:   lim = PCW'(DIV_A - 1);
      2'b01:   lim = PCW'(DIV_B - 1);
      default: lim = PCW'(DIV_C - 1);
    endcase
  end

  assign tick = run && (pc >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run) pc <= '0;
    else if (tick)   pc <= '0;
    else             pc <= pc + 1'b1;
  end

  // R3: prescale count never passes the slowest ratio
  p_pc_bound_r3: assert property (@(posedge clk) disable iff (rst)
    pc < PCW'(DMAX));
endmodule

// File: rtl/pwm10_core.sv
module pwm10_core #(
  parameter int RES = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           oe,
  input  logic           pol,
  input  logic           tick,
  input  logic [RES-1:0] per_m,
  input  logic [RES-1:0] duty_m,
  output logic           pin
);
  logic [RES-1:0] cnt, per_a, duty_s;
  logic           wrap, act, lvl;

  assign wrap = tick && (cnt == per_a);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      per_a  <= '0;
      duty_s <= '0;
    end else if (!run) begin
      cnt    <= '0;
      per_a  <= per_m;
      duty_s <= duty_m;
    end else if (wrap) begin
      cnt    <= '0;
      per_a  <= per_m;
      duty_s <= duty_m;
    end else if (tick) begin
      cnt    <= cnt + 1'b1;
    end
  end

  always_comb begin
    if (duty_s == per_a)   act = 1'b1;
    else if (duty_s == '0) act = 1'b0;
    else                   act = (cnt <= duty_s);
    lvl = run ? (act ~^ pol) : ~pol;
  end

  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else     pin <= oe & lvl;
  end

  // R2: count stays within the active period
  p_cnt_in_per_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= per_a);
  // R4: slave duty only moves at a wrap while running
  p_slave_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> $stable(duty_s));
  // R9: stopped timer holds the count at zero
  p_stop_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
  // R10: disabled output is low
  p_oe_low_r10: assert property (@(posedge clk) disable iff (rst)
    !oe |=> !pin);
endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
  import pwm10_pkg::*;
#(
  parameter int RES   = 10,
  parameter int REG_W = 8,
  parameter int DIV_A = 1,
  parameter int DIV_B = 2,
  parameter int DIV_C = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic             pwm_o
);
  ctrl_t          ctrl;
  logic [RES-1:0] per_m, duty_m;
  logic           tick;

  pwm10_regs #(.RES(RES), .REG_W(REG_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl), .per_m(per_m), .duty_m(duty_m)
  );

  pwm10_presc #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) presc_i (
    .clk(clk), .rst(rst), .run(ctrl.run), .sel(ctrl.clk_sel), .tick(tick)
  );

  pwm10_core #(.RES(RES)) core_i (
    .clk(clk), .rst(rst), .run(ctrl.run), .oe(ctrl.oe), .pol(ctrl.pol),
    .tick(tick), .per_m(per_m), .duty_m(duty_m), .pin(pwm_o)
  );

  // R11: output low in the cycle after reset
  p_rst_low_r11: assert property (@(posedge clk)
    rst |=> !pwm_o);
endmodule

// File: tb/pwm10_gen_tb_top.sv
module pwm10_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_o;

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R4";
  bit    model_cmp = 1'b0;

  always #10 clk = ~clk;

  pwm10_gen dut_i (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
                   .wr_data(wr_data), .pwm_o(pwm_o));

  // Reference model built from R1..R11
  logic [4:0] m_ctrl;
  logic [7:0] m_plo, m_dlo, m_hi;
  logic [9:0] m_pa, m_ds, m_cnt;
  int         m_pc;
  logic       m_exp;

  function automatic int div_of(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 8;
  endfunction

  function automatic logic lvl_of(input logic [9:0] c, input logic [9:0] d,
                                  input logic [9:0] p, input logic pl);
    logic a;
    if (d == p)       a = 1'b1;
    else if (d == 0)  a = 1'b0;
    else              a = (c <= d);
    return pl ? a : ~a;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl <= '0; m_plo <= '0; m_dlo <= '0; m_hi <= '0;
      m_pa <= '0; m_ds <= '0; m_cnt <= '0; m_pc <= 0; m_exp <= 1'b0;
    end else begin
      logic run, oe, pl, tk;
      logic [9:0] pm, dm;
      run = m_ctrl[0]; oe = m_ctrl[1]; pl = m_ctrl[2];
      pm = {m_hi[3:2], m_plo}; dm = {m_hi[1:0], m_dlo};
      m_exp <= oe & (run ? lvl_of(m_cnt, m_ds, m_pa, pl) : ~pl);
      if (!run) begin
        m_pc <= 0; m_cnt <= '0; m_pa <= pm; m_ds <= dm;
      end else begin
        tk = (m_pc >= div_of(m_ctrl[4:3]) - 1);
        m_pc <= tk ? 0 : m_pc + 1;
        if (tk) begin
          if (m_cnt == m_pa) begin
            m_cnt <= '0; m_pa <= pm; m_ds <= dm;
          end else m_cnt <= m_cnt + 1'b1;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_ctrl <= wr_data[4:0];
          2'd1: m_plo  <= wr_data;
          2'd2: m_dlo  <= wr_data;
          default: m_hi <= wr_data;
        endcase
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: pwm_o actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst && model_cmp) check(cur_req, pwm_o, m_exp);
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input bit oe, input bit pl, input logic [1:0] sel,
                       input int per, input int duty);
    wr(2'd0, {3'b0, sel, pl, oe, 1'b0});
    wr(2'd1, per[7:0]);
    wr(2'd2, duty[7:0]);
    wr(2'd3, {4'b0, per[9:8], duty[9:8]});
    wr(2'd0, {3'b0, sel, pl, oe, 1'b1});
  endtask

  task automatic measure(input int settle, input int len, output int hi);
    hi = 0;
    repeat (settle) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pwm_o) hi++;
    end
  endtask

  function automatic int exp_high(input int per, input int duty, input bit pl, input int dv);
    int a;
    if (duty == per)    a = per + 1;
    else if (duty == 0) a = 0;
    else                a = duty + 1;
    if (!pl) a = per + 1 - a;
    return a * dv;
  endfunction

  initial begin
    int hi;
    void'($urandom(32'h5eed_1234));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R11", pwm_o, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R11", pwm_o, 1'b0);
    model_cmp = 1'b1;

    // R2 and R3: steady-state active clocks over exactly one period, per select code
    for (int s = 0; s < 4; s++) begin
      cur_req = "R3";
      setup(1, 1, s[1:0], 9, 4);
      measure(30, 10 * div_of(s[1:0]), hi);
      check_int("R2/R3 active clocks", hi, exp_high(9, 4, 1, div_of(s[1:0])));
    end

    // R1: a 10-bit period and duty through the high register
    cur_req = "R1";
    setup(1, 1, 2'b00, 300, 260);
    measure(310, 301, hi);
    check_int("R1 ten-bit fields", hi, exp_high(300, 260, 1, 1));

    // R8: polarity 0 inverts the waveform
    cur_req = "R8";
    setup(1, 0, 2'b01, 11, 3);
    measure(40, 24, hi);
    check_int("R8 inverted active clocks", hi, exp_high(11, 3, 0, 2));

    // R6: duty equal to period gives a static active level
    cur_req = "R6";
    setup(1, 1, 2'b00, 7, 7);
    measure(20, 16, hi);
    check_int("R6 static active", hi, 16);
    setup(1, 0, 2'b00, 7, 7);
    measure(20, 16, hi);
    check_int("R6 static active pol0", hi, 0);

    // R7: duty zero gives a static inactive level
    cur_req = "R7";
    setup(1, 1, 2'b00, 7, 0);
    measure(20, 16, hi);
    check_int("R7 static inactive", hi, 0);

    // R5: a period-only change keeps the active time
    cur_req = "R5";
    setup(1, 1, 2'b00, 9, 4);
    repeat (15) @(negedge clk);
    wr(2'd1, 8'd19);
    measure(40, 20, hi);
    check_int("R5 active kept after period change", hi, 5);

    // R4: a duty write mid-cycle at a slow ratio
    cur_req = "R4";
    setup(1, 1, 2'b10, 15, 5);
    repeat (30) @(negedge clk);
    wr(2'd2, 8'd10);
    measure(300, 128, hi);
    check_int("R4 new duty after wrap", hi, exp_high(15, 10, 1, 8));

    // R10: disabled output stays low while running
    cur_req = "R10";
    setup(0, 1, 2'b00, 5, 2);
    measure(5, 30, hi);
    check_int("R10 disabled output", hi, 0);

    // R9: stopped output sits at inactive level
    cur_req = "R9";
    wr(2'd0, 8'b0000_0110);
    measure(3, 20, hi);
    check_int("R9 stopped inactive pol1", hi, 0);
    wr(2'd0, 8'b0000_0010);
    measure(3, 20, hi);
    check_int("R9 stopped inactive pol0", hi, 20);

    // Random register traffic while running, compared each cycle against the model
    cur_req = "R4";
    for (int k = 0; k < 1500; k++) begin
      int r;
      logic [1:0] a;
      logic [7:0] d;
      r = $urandom_range(0, 9);
      a = 2'($urandom_range(0, 3));
      d = 8'($urandom_range(0, 255));
      if (a == 2'd0) d = {3'b0, d[4:3], d[2], d[1], (r != 0)};
      if (a == 2'd1) d = 8'($urandom_range(0, 40));
      if (a == 2'd2) d = 8'($urandom_range(0, 40));
      if (a == 2'd3) d = {4'b0, 2'b00, 1'b0, d[0]};
      wr(a, d);
      repeat ($urandom_range(0, 12)) @(negedge clk);
    end

    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule